// File: doc/BRIEF.md
# Byte-Lane Data Mask Pipeline

This block applies per-byte masking to the 16-bit data path of a synchronous memory. It has one active-high mask bit per byte lane. The same mask bit acts in two ways, depending on the direction of the current burst.

During a write burst, a masked lane loses its write enable in the same cycle that the mask is presented. The array therefore never stores that byte. During a read burst, the mask bit travels down a two-stage pipeline beside the read data. The lane's output enable drops two cycles later, exactly when the beat it belongs to reaches the pins, and the driver is then tri-stated.

A beat counter tracks the position inside the burst. Masking never holds this counter back. The memory array and command decoding sit outside the block: the block only sees a burst-active flag and a write/read flag.

Top module: `dm_lane_mask`

## Requirements
- R1: `mask_i` is active high and has one bit per byte lane. Bit 0 governs data bits 7:0 and bit 1 governs data bits 15:8. A mask bit never affects the other lane.
- R2: `wen_o[l]` is high in a cycle exactly when `burst_i`=1, `write_i`=1 and `mask_i[l]`=0 in that same cycle. `wdata_o` always equals `wdata_i` unchanged.
- R3: If cycle n is a read beat (`burst_i`=1, `write_i`=0), then in cycle n+2 `oe_o[l]` is 0 when `mask_i[l]` was 1 in cycle n, and 1 when it was 0.
- R4: `rdata_o` in cycle n+2 equals `rdata_i` of cycle n, with the same polarity, whatever the mask.
- R5: Masks presented in consecutive read cycles each act only on their own output beat, with no merging or smearing between beats.
- R6: If cycle n is not a read beat (idle, or a write beat), both bits of `oe_o` are 0 in cycle n+2, regardless of `mask_i`.
- R7: `beat_o` is 0 in the first cycle of a burst and rises by one in each following burst cycle. It wraps modulo 8 and returns to 0 after an idle cycle. Masks never pause it.
- R8: An active-low asynchronous reset `rst_ni` at once forces `oe_o`, `rdata_o` and `beat_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_i | input | 1 | High while a burst beat is in progress |
| write_i | input | 1 | Burst direction: 1 write, 0 read |
| mask_i | input | 2 | Per-lane mask, bit 0 lower byte, bit 1 upper byte |
| wdata_i | input | 16 | Write data from the bus |
| rdata_i | input | 16 | Read data from the array |
| wdata_o | output | 16 | Write data toward the array |
| wen_o | output | 2 | Per-lane write enable toward the array |
| rdata_o | output | 16 | Read data toward the pins |
| oe_o | output | 2 | Per-lane output driver enable |
| beat_o | output | 3 | Beat index inside the current burst |

## Verification
A stuck or wrongly shifted read-mask stage shows as an output enable that is wrong in the exact cycle n+2 of the affected beat. An extra or missing stage shifts every masked beat by one cycle, so a table that alternates mask values over consecutive read cycles exposes it at the first transition. A write-side fault shows as a wrong write enable in the same cycle the mask is applied. A beat counter that stalls on masked cycles differs from the expected index by the next burst cycle.

// File: rtl/dm_pkg.sv
package dm_pkg;
  localparam int unsigned LANE_W  = 8;
  localparam int unsigned N_LANES = 2;
  localparam int unsigned DATA_W  = LANE_W * N_LANES;
  localparam int unsigned BEAT_W  = 3;
  localparam int unsigned RD_LAT  = 2;

  typedef logic [LANE_W-1:0] lane_t;
  typedef logic [N_LANES-1:0] lane_mask_t;
endpackage

// File: rtl/dm_wr_lane.sv
module dm_wr_lane #(
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_beat_i,
  input  logic              mask_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] wdata_o,
  output logic              wen_o
);
  // zero-latency mask: blocked in the same cycle it is sampled
  assign wen_o   = wr_beat_i & ~mask_i;
  assign wdata_o = wdata_i;

  AST_WR_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !wen_o); // R2
  AST_WR_PASS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_o == wdata_i); // R2
endmodule

// File: rtl/dm_rd_lane.sv
module dm_rd_lane #(
  parameter int unsigned LANE_W = 8,
  parameter int unsigned RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_beat_i,
  input  logic              mask_i,
  input  logic [LANE_W-1:0] rdata_i,
  output logic [LANE_W-1:0] rdata_o,
  output logic              oe_o
);
  logic              vld_q  [RD_LAT];
  logic              mask_q [RD_LAT];
  logic [LANE_W-1:0] data_q [RD_LAT];

  // one mask stage per beat, so back-to-back masks stay separate
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < RD_LAT; s++) begin
        vld_q[s]  <= 1'b0;
        mask_q[s] <= 1'b0;
        data_q[s] <= '0;
      end
    end else begin
      vld_q[0]  <= rd_beat_i;
      mask_q[0] <= mask_i;
      data_q[0] <= rdata_i;
      for (int s = 1; s < RD_LAT; s++) begin
        vld_q[s]  <= vld_q[s-1];
        mask_q[s] <= mask_q[s-1];
        data_q[s] <= data_q[s-1];
      end
    end
  end

  assign oe_o    = vld_q[RD_LAT-1] & ~mask_q[RD_LAT-1];
  assign rdata_o = data_q[RD_LAT-1];

  if (RD_LAT == 2) begin : g_ast
    AST_RD_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_beat_i && mask_i) |=> ##1 !oe_o); // R3
    AST_RD_UNMASK_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_beat_i && !mask_i) |=> ##1 oe_o); // R5
    AST_OE_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !rd_beat_i |=> ##1 !oe_o); // R6
    AST_RD_POLARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> ##1 rdata_o == $past(rdata_i, 2)); // R4
  end
endmodule

// File: rtl/dm_beat_ctr.sv
module dm_beat_ctr #(
  parameter int unsigned BEAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              burst_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  // advances on every burst cycle; masks are deliberately not an input
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (burst_i) beat_q <= beat_q + 1'b1;
    else              beat_q <= '0;
  end

  assign beat_o = beat_q;

  AST_BEAT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_i |=> beat_o == BEAT_W'($past(beat_o) + 1'b1)); // R7
  AST_BEAT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |=> beat_o == '0); // R7
endmodule

// File: rtl/dm_lane_mask.sv
module dm_lane_mask
  import dm_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                burst_i,
  input  logic                write_i,
  input  logic [N_LANES-1:0]  mask_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [DATA_W-1:0]   rdata_i,
  output logic [DATA_W-1:0]   wdata_o,
  output logic [N_LANES-1:0]  wen_o,
  output logic [DATA_W-1:0]   rdata_o,
  output logic [N_LANES-1:0]  oe_o,
  output logic [BEAT_W-1:0]   beat_o
);
  logic wr_beat, rd_beat;

  assign wr_beat = burst_i & write_i;
  assign rd_beat = burst_i & ~write_i;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    dm_wr_lane #(.LANE_W(LANE_W)) i_wr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_beat_i(wr_beat),
      .mask_i   (mask_i[l]),
      .wdata_i  (wdata_i[l*LANE_W +: LANE_W]),
      .wdata_o  (wdata_o[l*LANE_W +: LANE_W]),
      .wen_o    (wen_o[l])
    );

    dm_rd_lane #(.LANE_W(LANE_W), .RD_LAT(RD_LAT)) i_rd (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_beat_i(rd_beat),
      .mask_i   (mask_i[l]),
      .rdata_i  (rdata_i[l*LANE_W +: LANE_W]),
      .rdata_o  (rdata_o[l*LANE_W +: LANE_W]),
      .oe_o     (oe_o[l])
    );
  end

  dm_beat_ctr #(.BEAT_W(BEAT_W)) i_beat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .burst_i(burst_i),
    .beat_o (beat_o)
  );

  AST_WR_RD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    write_i |-> wen_o == (burst_i ? ~mask_i : '0)); // R1
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (oe_o == '0 && beat_o == '0)); // R8
endmodule

// File: tb/test_dm_lane_mask.sv
module test_dm_lane_mask;
  localparam int NV = 18;
  // {burst, write, mask[1:0], wdata[15:0], rdata[15:0]}
  localparam logic [35:0] VEC [NV] = '{
    {4'b0011, 16'h0000, 16'h0000},
    {4'b1100, 16'hA1B2, 16'h0000},
    {4'b1101, 16'hC3D4, 16'h0000},
    {4'b1110, 16'hE5F6, 16'h0000},
    {4'b1111, 16'h1357, 16'h0000},
    {4'b1000, 16'h0000, 16'h1122},
    {4'b1001, 16'h0000, 16'h3344},
    {4'b1010, 16'h0000, 16'h5566},
    {4'b1011, 16'h0000, 16'h7788},
    {4'b1000, 16'h0000, 16'h99AA},
    {4'b1001, 16'h0000, 16'hBBCC},
    {4'b0000, 16'h0000, 16'h0000},
    {4'b0011, 16'hFFFF, 16'hFFFF},
    {4'b1010, 16'h0000, 16'hDEAD},
    {4'b1101, 16'h2468, 16'hBEEF},
    {4'b0000, 16'h0000, 16'h0000},
    {4'b0000, 16'h0000, 16'h0000},
    {4'b1000, 16'h0000, 16'hF00D}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        burst_i = 1'b0;
  logic        write_i = 1'b0;
  logic [1:0]  mask_i = 2'b00;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_i = '0;
  logic [15:0] wdata_o, rdata_o;
  logic [1:0]  wen_o, oe_o;
  logic [2:0]  beat_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  dm_lane_mask i_dm_lane_mask (
    .clk_i, .rst_ni, .burst_i, .write_i, .mask_i, .wdata_i, .rdata_i,
    .wdata_o, .wen_o, .rdata_o, .oe_o, .beat_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [35:0] v);
    @(posedge clk_i);
    #2;
    {burst_i, write_i, mask_i, wdata_i, rdata_i} = v;
    #10;
  endtask

  function automatic logic [35:0] hist(input int j);
    return (j < 0) ? 36'h0 : VEC[j];
  endfunction

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [2:0] exp_beat;
    logic [35:0] cur, old2;
    #15;
    chk("R8 reset oe", {30'd0, oe_o}, 32'd0);
    chk("R8 reset beat", {29'd0, beat_o}, 32'd0);
    chk("R8 reset rdata", {16'd0, rdata_o}, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    drive(36'h0);
    drive(36'h0);

    exp_beat = '0;
    for (int i = 0; i < NV; i++) begin
      cur  = VEC[i];
      old2 = hist(i - 2);
      if (i > 0 && hist(i - 1)[35]) exp_beat = exp_beat + 3'd1;
      else exp_beat = '0;
      drive(cur);
      // R1 R2: same-cycle per-lane write enable
      chk("R2 wen", {30'd0, wen_o},
          {30'd0, (cur[35] & cur[34]) ? ~cur[33:32] : 2'b00});
      chk("R2 wdata", {16'd0, wdata_o}, {16'd0, cur[31:16]});
      // R3 R5 R6: enable two cycles after the mask
      chk("R3 R5 R6 oe", {30'd0, oe_o},
          {30'd0, (old2[35] & ~old2[34]) ? ~old2[33:32] : 2'b00});
      chk("R4 rdata", {16'd0, rdata_o}, {16'd0, old2[15:0]});
      chk("R7 beat", {29'd0, beat_o}, {29'd0, exp_beat});
    end

    // R7: wrap past 8 with masks toggling every beat
    drive(36'h0);
    for (int k = 0; k < 10; k++) begin
      drive({3'b100, k[0], 16'h0, 16'h0});
      chk("R7 beat wrap", {29'd0, beat_o}, {29'd0, 3'(k)});
    end

    // R1: only the lower lane masked, upper lane stays enabled two cycles on
    drive({4'b1001, 16'h0, 16'h55AA});
    drive({4'b1000, 16'h0, 16'h0});
    drive({4'b0000, 16'h0, 16'h0});
    chk("R1 lane separation", {30'd0, oe_o}, 32'd2);
    chk("R1 data", {16'd0, rdata_o}, 32'h55AA);

    // R8: async reset in mid read burst
    drive({4'b1000, 16'h0, 16'h1234});
    drive({4'b1000, 16'h0, 16'h1234});
    drive({4'b1000, 16'h0, 16'h1234});
    chk("R3 oe before reset", {30'd0, oe_o}, 32'd3);
    rst_ni = 1'b0;
    #1;
    chk("R8 async oe", {30'd0, oe_o}, 32'd0);
    chk("R8 async beat", {29'd0, beat_o}, 32'd0);
    chk("R8 async rdata", {16'd0, rdata_o}, 32'd0);
    #20;
    rst_ni = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule